// File: doc/BRIEF.md
# Secondary Bus Reset Sequencer

This block turns a software-written reset bit into a clean reset of a bridge's downstream bus segment. Software writes the bit through a one-bit write port and can read it back. When the bit goes to 1, the sequencer does not cut into a transfer that is already running on the downstream bus. It waits until the bus-busy indication drops, and only then drives the active-low downstream bus reset. A local reset to the bridge's data buffers and downstream bus-interface logic is driven alongside it. Nothing else in the bridge is reset by this block: upstream link logic, configuration storage and the interrupt and hot-plug logic are left alone.

When software clears the bit, the bus reset is released, but never before a minimum assertion width has passed. After release, the block waits through a short recovery window before it accepts a new reset request. If software clears the bit while the block is still waiting for the bus to go idle, the request is dropped and no reset is ever driven. Both outputs come straight from flip-flops, so they cannot glitch.

Top module: `sec_bus_reset_seq`

## Requirements
- R1: With the bus idle, a write of 1 to the control bit drives `busRstN` low after the second rising edge that follows the write cycle: one edge loads the bit and the next edge acts on it.
- R2: Once the minimum width has passed, the edge after the control bit reads 0 returns `busRstN` high.
- R3: While `busBusy` is 1, a pending request does not assert `busRstN`. The reset is taken at the first edge where the stored bit is 1 and `busBusy` is 0.
- R4: If the stored bit is 0 at an edge where a request is still waiting for the bus, the request is dropped and `busRstN` stays high. A clear write that lands at the same edge the bus goes idle does not cancel the request, because the decision at that edge uses the old stored bit.
- R5: Once asserted, `busRstN` stays low for at least `MIN_ASSERT_CYCLES` cycles. A clear written in the entry cycle gives exactly that width.
- R6: `bufRst` is 1 in exactly the cycles in which `busRstN` is 0.
- R7: After release, a new request is held off during a recovery window of `RELEASE_CYCLES` cycles. If the bit is set again in the cycle right after release, `busRstN` stays high for `RELEASE_CYCLES`+1 cycles before it falls again.
- R8: `ctlRdData` returns the stored control bit. It resets to 0, and a write shows on it after the edge that ends the write cycle.
- R9: While `rstN` is low, `busRstN` is 1, `bufRst` is 0 and `ctlRdData` is 0. This also holds when `rstN` is pulled low in the middle of a bus reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset of the block |
| ctlWrEn | input | 1 | Write strobe for the control bit |
| ctlWrData | input | 1 | Value written to the control bit (1 requests a bus reset) |
| busBusy | input | 1 | 1 while a transaction is in progress on the downstream bus |
| ctlRdData | output | 1 | Read-back of the stored control bit |
| busRstN | output | 1 | Registered active-low downstream bus reset |
| bufRst | output | 1 | Registered active-high reset for buffers and bus-interface logic |

## Verification
Two events can meet at one clock edge: the bus-idle event that starts a deferred reset, and a software clear that cancels it. The bench holds a request in the waiting state with `busBusy` high. In one case it drops `busBusy` in the same cycle as a clear write. In the other it keeps `busBusy` high until after the clear has landed. The first case must give a reset of exactly `MIN_ASSERT_CYCLES` cycles. The second must give no reset at all over a long observation window.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [1:0] {
    IDLE          = 2'd0,
    WAIT_BUS_IDLE = 2'd1,
    IN_RESET      = 2'd2,
    RELEASE       = 2'd3
  } sbrState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rstSet;   // drive bus reset and local reset
    logic rstClr;   // release both resets
    logic cntClr;   // restart the width counter
    logic cntInc;   // advance the width counter
  } sbrStrobe_t;

endpackage

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
  import sbr_pkg::*;
#(
  parameter int MIN_ASSERT_CYCLES = 8,
  parameter int RELEASE_CYCLES    = 4,
  parameter int CNT_W             = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlBit,
  input  logic             busBusy,
  input  logic [CNT_W-1:0] cnt,
  output sbrStrobe_t       strb
);

  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(MIN_ASSERT_CYCLES - 1);
  localparam logic [CNT_W-1:0] REL_LAST  = CNT_W'(RELEASE_CYCLES - 1);

  sbrState_e stateQ, stateD;
  logic      holdDone, relDone;

  assign holdDone = (cnt >= HOLD_LAST);
  assign relDone  = (cnt >= REL_LAST);

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      IDLE: begin
        if (ctlBit) begin
          if (!busBusy) begin
            stateD      = IN_RESET;
            strb.rstSet = 1'b1;
            strb.cntClr = 1'b1;
          end else begin
            stateD = WAIT_BUS_IDLE;
          end
        end
      end
      WAIT_BUS_IDLE: begin
        if (!ctlBit) begin
          stateD = IDLE;
        end else if (!busBusy) begin
          stateD      = IN_RESET;
          strb.rstSet = 1'b1;
          strb.cntClr = 1'b1;
        end
      end
      IN_RESET: begin
        strb.cntInc = 1'b1;
        if (!ctlBit && holdDone) begin
          stateD      = RELEASE;
          strb.rstClr = 1'b1;
          strb.cntClr = 1'b1;
          strb.cntInc = 1'b0;
        end
      end
      RELEASE: begin
        strb.cntInc = 1'b1;
        if (relDone) begin
          stateD      = IDLE;
          strb.cntInc = 1'b0;
        end
      end
      default: stateD = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= IDLE;
    else       stateQ <= stateD;
  end

  AST_HOLD_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == IN_RESET && !holdDone) |=> (stateQ == IN_RESET)); // R5

  AST_CLEAR_CANCELS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == WAIT_BUS_IDLE && !ctlBit) |=> (stateQ == IDLE)); // R4

  AST_RECOVERY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == RELEASE && !relDone) |=> (stateQ == RELEASE)); // R7

endmodule

// File: rtl/sbr_dpath.sv
module sbr_dpath
  import sbr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWrEn,
  input  logic             ctlWrData,
  input  sbrStrobe_t       strb,
  output logic             ctlBit,
  output logic [CNT_W-1:0] cnt,
  output logic             busRstN,
  output logic             bufRst
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             ctlBitQ;
  logic [CNT_W-1:0] cntQ;
  logic             busRstNQ;
  logic             bufRstQ;

  // software control bit, resets to 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        ctlBitQ <= 1'b0;
    else if (ctlWrEn) ctlBitQ <= ctlWrData;
  end

  // width counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              cntQ <= '0;
    else if (strb.cntClr)                   cntQ <= '0;
    else if (strb.cntInc && cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
  end

  // registered reset outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRstNQ <= 1'b1;
      bufRstQ  <= 1'b0;
    end else if (strb.rstSet) begin
      busRstNQ <= 1'b0;
      bufRstQ  <= 1'b1;
    end else if (strb.rstClr) begin
      busRstNQ <= 1'b1;
      bufRstQ  <= 1'b0;
    end
  end

  assign ctlBit  = ctlBitQ;
  assign cnt     = cntQ;
  assign busRstN = busRstNQ;
  assign bufRst  = bufRstQ;

  AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rstSet, strb.rstClr})); // R2

endmodule

// File: rtl/sec_bus_reset_seq.sv
module sec_bus_reset_seq
  import sbr_pkg::*;
#(
  parameter int MIN_ASSERT_CYCLES = 8,
  parameter int RELEASE_CYCLES    = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic ctlWrEn,
  input  logic ctlWrData,
  input  logic busBusy,
  output logic ctlRdData,
  output logic busRstN,
  output logic bufRst
);

  localparam int LONGEST = (MIN_ASSERT_CYCLES > RELEASE_CYCLES) ? MIN_ASSERT_CYCLES : RELEASE_CYCLES;
  localparam int CNT_W   = $clog2(LONGEST + 1);

  sbrStrobe_t       strb;
  logic             ctlBit;
  logic [CNT_W-1:0] cnt;

  initial begin
    if (MIN_ASSERT_CYCLES < 1 || RELEASE_CYCLES < 1)
      $error("sec_bus_reset_seq: cycle parameters must be at least 1");
  end

  sbr_ctrl #(
    .MIN_ASSERT_CYCLES(MIN_ASSERT_CYCLES),
    .RELEASE_CYCLES   (RELEASE_CYCLES),
    .CNT_W            (CNT_W)
  ) uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .ctlBit (ctlBit),
    .busBusy(busBusy),
    .cnt    (cnt),
    .strb   (strb)
  );

  sbr_dpath #(
    .CNT_W(CNT_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctlWrEn  (ctlWrEn),
    .ctlWrData(ctlWrData),
    .strb     (strb),
    .ctlBit   (ctlBit),
    .cnt      (cnt),
    .busRstN  (busRstN),
    .bufRst   (bufRst)
  );

  assign ctlRdData = ctlBit;

  AST_DEFER_UNTIL_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busRstN) |-> $past(!busBusy)); // R3

  AST_ASSERT_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busRstN) |-> $past(ctlRdData)); // R1

endmodule

// File: tb/sim_sec_bus_reset_seq.sv
module sim_sec_bus_reset_seq;

  localparam int MIN_W = 8;
  localparam int REL_W = 4;

  logic clk = 1'b0;
  logic rstN, ctlWrEn, ctlWrData, busBusy;
  logic ctlRdData, busRstN, bufRst;
  int   nChk = 0, nBad = 0, cyc = 0;

  always #5 clk = ~clk;

  sec_bus_reset_seq #(.MIN_ASSERT_CYCLES(MIN_W), .RELEASE_CYCLES(REL_W)) u0 (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .busBusy(busBusy), .ctlRdData(ctlRdData), .busRstN(busRstN), .bufRst(bufRst)
  );

  // watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      nBad = nBad + 1;
      $display("FAIL watchdog: act=%0d exp<100000 cycles", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk + 1, nBad);
      $finish;
    end
  end

  // R6: bufRst mirrors active busRstN every cycle
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      nChk = nChk + 1;
      if (bufRst !== ~busRstN) begin
        nBad = nBad + 1;
        $display("FAIL R6 bufRst: act=%b exp=%b", bufRst, ~busRstN);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    nChk = nChk + 1;
    if (act !== exp) begin
      nBad = nBad + 1;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic chkInt(input string req, input int act, input int exp);
    nChk = nChk + 1;
    if (act != exp) begin
      nBad = nBad + 1;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; ctlWrEn = 1'b0; ctlWrData = 1'b0; busBusy = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // drive one write over one rising edge, return at the next negedge
  task automatic wr(input logic v);
    ctlWrEn = 1'b1; ctlWrData = v;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  // {wrEn, wrData, busy, expBusRstN, expBufRst, expRd}
  localparam logic [5:0] VEC [0:13] = '{
    6'b000_100, 6'b111_101, 6'b001_101, 6'b001_101,
    6'b000_011, 6'b001_011, 6'b100_010, 6'b000_010,
    6'b000_010, 6'b000_010, 6'b000_010, 6'b000_010,
    6'b000_100, 6'b000_100
  };

  initial begin
    int lowCnt, hiCnt;
    logic sawLow;
    doReset();

    // R9 reset state
    chk("R9 busRstN after reset", busRstN, 1'b1);
    chk("R9 bufRst after reset", bufRst, 1'b0);
    chk("R8 ctlRdData reset value", ctlRdData, 1'b0);

    // table: busy deferral, assert, early clear, min width, release
    for (int i = 0; i < 14; i++) begin
      ctlWrEn = VEC[i][5]; ctlWrData = VEC[i][4]; busBusy = VEC[i][3];
      @(negedge clk);
      chk($sformatf("R3/R5 table row %0d busRstN", i), busRstN, VEC[i][2]);
      chk($sformatf("R6 table row %0d bufRst", i), bufRst, VEC[i][1]);
      chk($sformatf("R8 table row %0d ctlRdData", i), ctlRdData, VEC[i][0]);
    end
    ctlWrEn = 1'b0; busBusy = 1'b0;

    // R1 immediate assert with bus idle, R2 release after long hold
    doReset();
    wr(1'b1);
    chk("R8 readback after write", ctlRdData, 1'b1);
    chk("R1 not yet asserted one edge after write", busRstN, 1'b1);
    @(negedge clk);
    chk("R1 asserted two edges after write", busRstN, 1'b0);
    repeat (20) @(negedge clk);
    chk("R1 held while bit set", busRstN, 1'b0);
    wr(1'b0);
    chk("R2 still low on the edge that clears bit", busRstN, 1'b0);
    @(negedge clk);
    chk("R2 released edge after bit clears", busRstN, 1'b1);

    // R7 re-request straight after release
    hiCnt = 1;
    ctlWrEn = 1'b1; ctlWrData = 1'b1;
    @(negedge clk);
    ctlWrEn = 1'b0;
    while (busRstN === 1'b1 && hiCnt < 100) begin
      hiCnt++;
      @(negedge clk);
    end
    chkInt("R7 recovery gap length", hiCnt, REL_W + 1);

    // R5 clear written in entry cycle: exact minimum width
    doReset();
    wr(1'b1);
    wr(1'b0);
    lowCnt = 0;
    while (busRstN === 1'b0 && lowCnt < 100) begin
      lowCnt++;
      @(negedge clk);
    end
    chkInt("R5 minimum width", lowCnt, MIN_W);

    // R4 abort: clear lands while bus still busy
    doReset();
    busBusy = 1'b1;
    wr(1'b1);
    repeat (5) @(negedge clk);
    wr(1'b0);
    busBusy = 1'b0;
    sawLow = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (busRstN !== 1'b1) sawLow = 1'b1;
    end
    chk("R4 cancelled request never asserts", sawLow, 1'b0);
    chk("R4 bit reads 0 after cancel", ctlRdData, 1'b0);

    // R4 coincident: bus goes idle at the edge the clear lands
    doReset();
    busBusy = 1'b1;
    wr(1'b1);
    repeat (5) @(negedge clk);
    chk("R3 waiting while busy", busRstN, 1'b1);
    ctlWrEn = 1'b1; ctlWrData = 1'b0; busBusy = 1'b0;
    @(negedge clk);
    ctlWrEn = 1'b0;
    lowCnt = 0;
    while (busRstN === 1'b0 && lowCnt < 100) begin
      lowCnt++;
      @(negedge clk);
    end
    chkInt("R4 coincident idle and clear gives minimum reset", lowCnt, MIN_W);

    // R9 hard reset in the middle of a bus reset
    doReset();
    wr(1'b1);
    repeat (3) @(negedge clk);
    chk("R1 asserted before hard reset", busRstN, 1'b0);
    rstN = 1'b0;
    #1;
    chk("R9 busRstN released by hard reset", busRstN, 1'b1);
    chk("R9 bufRst released by hard reset", bufRst, 1'b0);
    chk("R9 bit cleared by hard reset", ctlRdData, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 stays released after hard reset", busRstN, 1'b1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule